// File: doc/BRIEF.md
# Storage Write Guard with Two-Step Control Unlock

This block stands between a decoded write-transaction stream and two kinds of storage: a 2 KB byte array with an 11-bit address, and a small bank of clock/control registers kept in nonvolatile cells. Each cycle may carry one write beat with a target, an address, a data byte and an end-of-transaction flag. Array beats are passed to the array write port unless the address lies in the range chosen by a 3-bit protect field. Status beats feed two volatile latches that together unlock control writes. Control transactions write one to eight consecutive registers and then hold the block busy for a programmable nonvolatile write time.

The guard is a four-state machine. In `ST_IDLE` it routes array and status beats and checks each new control transaction against the latches. Transition IDLE→BURST takes an unlocked control beat that is not the last. IDLE→BUSY takes an unlocked control beat that is also the last. IDLE→DROP takes a locked control beat that is not the last; a locked single-beat transaction stays in IDLE. In `ST_BURST` further control beats write successive registers; its last beat gives BURST→BUSY. In `ST_DROP` control beats are swallowed until the last one gives DROP→IDLE. `ST_BUSY` rejects every beat and leaves through BUSY→IDLE when the timer expires, clearing the register-write latch.

Top module: `wp_gate`

## Requirements
- R1: Target code 2'b00 is the array. With protect field 000 no array address is blocked. With 001, addresses 600h–7FFh are blocked. With 010, 400h–7FFh are blocked. With 011, every address is blocked. A blocked beat leaves `arr_we_o` low.
- R2: With protect field 1xx, the blocked range starts at 000h and covers 64 << xx bytes: 03Fh for 100, 07Fh for 101, 0FFh for 110 and 1FFh for 111.
- R3: An array beat that is not blocked raises `arr_we_o` in the same cycle, with `arr_addr_o` and `arr_data_o` equal to the beat's address and data.
- R4: Target code 2'b01 is the status register. Data 02h sets `wel_o`. Data 06h sets both `wel_o` and `rwel_o`. Any other value leaves both latches unchanged. The latch outputs change at the clock edge that ends the beat.
- R5: Target code 2'b10 is the control bank. A control transaction whose first beat arrives while `wel_o` or `rwel_o` is low writes nothing in any of its beats and does not start a busy period.
- R6: An unlocked control transaction writes register start+k on its beat k, with that beat's data, for k from 0 to 7. Beats after the eighth are dropped.
- R7: Register addresses of 48 and above are undefined. A beat aimed at one raises no `ccr_we_o`, although it still advances the beat index.
- R8: The edge that ends the last beat of an unlocked control transaction raises `busy_o`, which stays high for exactly BUSY_CYCLES cycles. When it falls, `rwel_o` clears and `wel_o` keeps its value.
- R9: While `busy_o` is high, no array, status or control beat has any effect.
- R10: After reset, `wel_o`, `rwel_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bp_i | input | 3 | Block-protect field |
| req_valid | input | 1 | A write beat is present |
| req_target | input | 2 | Beat target: 00 array, 01 status, 10 control |
| req_addr | input | 11 | Array address, or the start register for a control transaction |
| req_data | input | 8 | Write data byte |
| req_last | input | 1 | Beat is the last of its transaction |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 11 | Array write address |
| arr_data_o | output | 8 | Array write data |
| ccr_we_o | output | 1 | Control register write strobe |
| ccr_addr_o | output | 6 | Control register address |
| ccr_data_o | output | 8 | Control register data |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write-enable latch |
| busy_o | output | 1 | Nonvolatile write cycle in progress |

## Verification
The hardest case to reach is a beat that arrives during the busy window and would change something if it were accepted. It is only possible after the full unlock sequence has completed and a control burst has been accepted. The bench therefore sends 06h, then a ten-beat burst that runs past the eight-register limit. Within the following busy cycles it fires an unblocked array write, a status key and a new control beat, while it counts the busy cycles one by one. Undefined registers are reached by a second unlocked burst that starts three registers below the end of the bank.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef enum logic [1:0] {
        TGT_ARRAY  = 2'b00,
        TGT_STATUS = 2'b01,
        TGT_CTRL   = 2'b10,
        TGT_NONE   = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BURST,
        ST_DROP,
        ST_BUSY
    } st_e;

    localparam logic [7:0] KEY_WEL  = 8'h02;
    localparam logic [7:0] KEY_BOTH = 8'h06;

endpackage

// File: rtl/wpg_range.sv
module wpg_range #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64
) (
    input  logic [2:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int LIM_W = ADDR_W + 4;

    logic [LIM_W-1:0] page_lim;

    // first-pages limit: PAGE_BYTES scaled by 1, 2, 4 or 8
    assign page_lim = LIM_W'(PAGE_BYTES) << bp_i[1:0];

    always_comb begin
        unique case (bp_i)
            3'b000:  hit_o = 1'b0;
            3'b001:  hit_o = addr_i[ADDR_W-1] & addr_i[ADDR_W-2];
            3'b010:  hit_o = addr_i[ADDR_W-1];
            3'b011:  hit_o = 1'b1;
            default: hit_o = LIM_W'(addr_i) < page_lim;
        endcase
    end
endmodule

// File: rtl/wpg_latch.sv
module wpg_latch
    import wpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid_i,
    input  logic [7:0] key_data_i,
    input  logic       clr_reg_i,
    output logic       wel_o,
    output logic       rwel_o
);
    logic key_wel, key_both;

    assign key_wel  = key_valid_i && (key_data_i == KEY_WEL);
    assign key_both = key_valid_i && (key_data_i == KEY_BOTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_o  <= 1'b0;
            rwel_o <= 1'b0;
        end else begin
            if (key_wel || key_both)
                wel_o <= 1'b1;
            if (key_both)
                rwel_o <= 1'b1;
            else if (clr_reg_i)
                rwel_o <= 1'b0;
        end
    end
endmodule

// File: rtl/wpg_timer.sv
module wpg_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CW'(CYCLES);
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = run_i && (cnt_q == CW'(1));
endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import wpg_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 64,
    parameter int CCR_AW      = 6,
    parameter int CCR_REGS    = 48,
    parameter int MAX_BURST   = 8,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bp_i,
    input  logic              req_valid,
    input  logic [1:0]        req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              req_last,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_data_o,
    output logic              ccr_we_o,
    output logic [CCR_AW-1:0] ccr_addr_o,
    output logic [7:0]        ccr_data_o,
    output logic              wel_o,
    output logic              rwel_o,
    output logic              busy_o
);
    localparam int NA_W = ADDR_W + 1;
    localparam int BC_W = $clog2(MAX_BURST + 1);
    localparam logic [NA_W-1:0] REG_LIM   = NA_W'(CCR_REGS);
    localparam logic [BC_W-1:0] BURST_LIM = BC_W'(MAX_BURST);

    st_e              st_q, st_d;
    tgt_e             tgt;
    logic             hit, tmr_done, tmr_start;
    logic             is_ctrl, unlocked, first_ok, more_ok;
    logic             key_valid;
    logic [NA_W-1:0]  nxt_q;
    logic [BC_W-1:0]  beats_q;

    assign tgt      = tgt_e'(req_target);
    assign is_ctrl  = req_valid && (tgt == TGT_CTRL);
    assign unlocked = wel_o && rwel_o;

    wpg_range #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_range (
        .bp_i   (bp_i),
        .addr_i (req_addr),
        .hit_o  (hit)
    );

    wpg_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_valid_i (key_valid),
        .key_data_i  (req_data),
        .clr_reg_i   (tmr_done),
        .wel_o       (wel_o),
        .rwel_o      (rwel_o)
    );

    wpg_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .run_i   (busy_o),
        .done_o  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (is_ctrl) begin
                    if (unlocked)
                        st_d = req_last ? ST_BUSY : ST_BURST;
                    else
                        st_d = req_last ? ST_IDLE : ST_DROP;
                end
            end
            ST_BURST: if (is_ctrl && req_last) st_d = ST_BUSY;
            ST_DROP:  if (is_ctrl && req_last) st_d = ST_IDLE;
            ST_BUSY:  if (tmr_done)            st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // burst address and beat count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q   <= '0;
            beats_q <= '0;
        end else if (first_ok) begin
            nxt_q   <= NA_W'(req_addr) + 1'b1;
            beats_q <= BC_W'(1);
        end else if (st_q == ST_BURST && is_ctrl) begin
            nxt_q   <= nxt_q + 1'b1;
            if (beats_q != BURST_LIM)
                beats_q <= beats_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        first_ok   = (st_q == ST_IDLE) && is_ctrl && unlocked;
        more_ok    = (st_q == ST_BURST) && is_ctrl && (beats_q < BURST_LIM);
        key_valid  = (st_q == ST_IDLE) && req_valid && (tgt == TGT_STATUS);
        arr_we_o   = (st_q == ST_IDLE) && req_valid && (tgt == TGT_ARRAY) && !hit;
        arr_addr_o = req_addr;
        arr_data_o = req_data;
        ccr_we_o   = (first_ok && (NA_W'(req_addr) < REG_LIM))
                   || (more_ok && (nxt_q < REG_LIM));
        ccr_addr_o = first_ok ? req_addr[CCR_AW-1:0] : nxt_q[CCR_AW-1:0];
        ccr_data_o = req_data;
        tmr_start  = (first_ok || (st_q == ST_BURST && is_ctrl)) && req_last;
        busy_o     = (st_q == ST_BUSY);
    end
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
    parameter int CCR_AW   = 6,
    parameter int CCR_REGS = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_target,
    input logic              req_last,
    input logic              arr_we_o,
    input logic              ccr_we_o,
    input logic [CCR_AW-1:0] ccr_addr_o,
    input logic              wel_o,
    input logic              rwel_o,
    input logic              busy_o
);
    localparam int CK_W = CCR_AW + 1;

    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!arr_we_o && !ccr_we_o));

    a_r5_ctrl_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_we_o |-> (wel_o && rwel_o));

    a_r7_defined_only: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_we_o |-> (CK_W'(ccr_addr_o) < CK_W'(CCR_REGS)));

    a_r8_rwel_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rwel_o) |-> $fell(busy_o));

    a_r8_busy_from_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_valid && req_last && req_target == 2'b10));

    a_r4_wel_from_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_o) |-> $past(req_valid && req_target == 2'b01 && !busy_o));

    a_r4_rwel_with_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rwel_o) |-> wel_o);
endmodule

bind wp_gate wpg_checker #(.CCR_AW(CCR_AW), .CCR_REGS(CCR_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_target (req_target),
    .req_last   (req_last),
    .arr_we_o   (arr_we_o),
    .ccr_we_o   (ccr_we_o),
    .ccr_addr_o (ccr_addr_o),
    .wel_o      (wel_o),
    .rwel_o     (rwel_o),
    .busy_o     (busy_o)
);

// File: tb/sim_wp_gate.sv
`timescale 1ns/1ps
module sim_wp_gate;
    localparam int BUSY_N = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bp_i = 3'b000;
    logic        req_valid = 1'b0;
    logic [1:0]  req_target = 2'b11;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_last = 1'b0;
    logic        arr_we_o, ccr_we_o, wel_o, rwel_o, busy_o;
    logic [10:0] arr_addr_o;
    logic [7:0]  arr_data_o, ccr_data_o;
    logic [5:0]  ccr_addr_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wp_gate #(.BUSY_CYCLES(BUSY_N)) u0 (
        .clk(clk), .rst_n(rst_n), .bp_i(bp_i), .req_valid(req_valid),
        .req_target(req_target), .req_addr(req_addr), .req_data(req_data),
        .req_last(req_last), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_data_o(arr_data_o), .ccr_we_o(ccr_we_o), .ccr_addr_o(ccr_addr_o),
        .ccr_data_o(ccr_data_o), .wel_o(wel_o), .rwel_o(rwel_o), .busy_o(busy_o)
    );

    function automatic bit f_prot(input logic [2:0] bp, input int a);
        case (bp)
            3'b000:  return 1'b0;
            3'b001:  return a >= 'h600;
            3'b010:  return a >= 'h400;
            3'b011:  return 1'b1;
            default: return a < (64 << bp[1:0]);
        endcase
    endfunction

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] t, input int a, input int d, input bit l);
        @(negedge clk);
        req_valid  = 1'b1;
        req_target = t;
        req_addr   = 11'(a);
        req_data   = 8'(d);
        req_last   = l;
        #2;
    endtask

    task automatic rest();
        @(negedge clk);
        req_valid = 1'b0;
        req_last  = 1'b0;
        #2;
    endtask

    task automatic arr_case(input logic [2:0] bp, input int a, input int d);
        bit exp_we;
        bp_i = bp;
        put(2'b00, a, d, 1'b1);
        exp_we = !f_prot(bp, a);
        if (bp[2]) chk(arr_we_o == exp_we, "R2", arr_we_o, exp_we);
        else       chk(arr_we_o == exp_we, "R1", arr_we_o, exp_we);
        if (exp_we) chk(arr_addr_o == 11'(a) && arr_data_o == 8'(d), "R3",
                        {arr_addr_o, arr_data_o}, {11'(a), 8'(d)});
    endtask

    task automatic wait_idle();
        while (busy_o) rest();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            nvec++;
            $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int bnd [14] = '{'h000, 'h03F, 'h040, 'h07F, 'h080, 'h0FF, 'h100,
                         'h1FF, 'h200, 'h3FF, 'h400, 'h5FF, 'h600, 'h7FF};
        int nb;
        bit m_wel, m_rwel;
        void'($urandom(32'h5EED_0017));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rest();
        // R10 reset state
        chk({wel_o, rwel_o, busy_o} == 3'b000, "R10", {wel_o, rwel_o, busy_o}, 0);

        // R1 / R2 / R3 directed boundaries
        for (int b = 0; b < 8; b++)
            for (int i = 0; i < 14; i++)
                arr_case(3'(b), bnd[i], (b * 16 + i) & 8'hFF);

        // random array traffic
        for (int i = 0; i < 300; i++)
            arr_case(3'($urandom % 8), int'($urandom % 2048), int'($urandom % 256));
        bp_i = 3'b000;

        // R4 stray status value
        put(2'b01, 0, 'h03, 1'b1); rest();
        chk({wel_o, rwel_o} == 2'b00, "R4", {wel_o, rwel_o}, 0);

        // R5 locked multi-beat control transaction
        put(2'b10, 5, 'hAA, 1'b0);
        chk(ccr_we_o == 1'b0, "R5", ccr_we_o, 0);
        put(2'b10, 0, 'hBB, 1'b1);
        chk(ccr_we_o == 1'b0, "R5", ccr_we_o, 0);
        rest();
        chk(busy_o == 1'b0, "R5", busy_o, 0);

        // R4 02h sets wel only
        put(2'b01, 0, 'h02, 1'b1); rest();
        chk({wel_o, rwel_o} == 2'b10, "R4", {wel_o, rwel_o}, 2);
        // R5 wel alone is not enough
        put(2'b10, 2, 'h11, 1'b1);
        chk(ccr_we_o == 1'b0, "R5", ccr_we_o, 0);
        rest();
        chk(busy_o == 1'b0, "R5", busy_o, 0);
        // R4 other value leaves latches
        put(2'b01, 0, 'h07, 1'b1); rest();
        chk({wel_o, rwel_o} == 2'b10, "R4", {wel_o, rwel_o}, 2);
        put(2'b01, 0, 'h06, 1'b1); rest();
        chk({wel_o, rwel_o} == 2'b11, "R4", {wel_o, rwel_o}, 3);

        // R6 ten-beat burst from register 3
        for (int k = 0; k < 10; k++) begin
            put(2'b10, (k == 0) ? 3 : 0, 'h40 + k, k == 9);
            if (k < 8) begin
                chk(ccr_we_o == 1'b1, "R6", ccr_we_o, 1);
                chk(ccr_addr_o == 6'(3 + k) && ccr_data_o == 8'('h40 + k), "R6",
                    {ccr_addr_o, ccr_data_o}, {6'(3 + k), 8'('h40 + k)});
            end else begin
                chk(ccr_we_o == 1'b0, "R6", ccr_we_o, 0);
            end
        end

        // R8 / R9 busy window
        nb = 0;
        rest();
        while (busy_o) begin
            nb++;
            if (nb == 1) begin
                put(2'b00, 'h300, 'h5A, 1'b1);
                chk(arr_we_o == 1'b0, "R9", arr_we_o, 0);
            end else if (nb == 2) begin
                put(2'b10, 1, 'h77, 1'b1);
                chk(ccr_we_o == 1'b0, "R9", ccr_we_o, 0);
            end else if (nb == 3) begin
                put(2'b01, 0, 'h06, 1'b1);
            end else begin
                rest();
            end
        end
        chk(nb == BUSY_N, "R8", nb, BUSY_N);
        chk({wel_o, rwel_o} == 2'b10, "R8", {wel_o, rwel_o}, 2);
        rest();
        chk(busy_o == 1'b0, "R9", busy_o, 0);

        // R7 burst crossing into undefined registers
        put(2'b01, 0, 'h06, 1'b1); rest();
        for (int k = 0; k < 5; k++) begin
            put(2'b10, (k == 0) ? 45 : 0, 'h90 + k, k == 4);
            if (k < 3) chk(ccr_we_o == 1'b1 && ccr_addr_o == 6'(45 + k), "R7",
                           {ccr_we_o, ccr_addr_o}, {1'b1, 6'(45 + k)});
            else       chk(ccr_we_o == 1'b0, "R7", ccr_we_o, 0);
        end
        rest();
        chk(busy_o == 1'b1, "R8", busy_o, 1);
        wait_idle();

        // R4 random status bytes against a latch model
        m_wel  = wel_o;
        m_rwel = rwel_o;
        for (int i = 0; i < 60; i++) begin
            int v;
            v = int'($urandom % 256);
            if ($urandom % 4 == 0) v = ($urandom % 2) ? 'h02 : 'h06;
            put(2'b01, 0, v, 1'b1); rest();
            if (v == 'h02) m_wel = 1'b1;
            if (v == 'h06) begin m_wel = 1'b1; m_rwel = 1'b1; end
            chk({wel_o, rwel_o} == {m_wel, m_rwel}, "R4", {wel_o, rwel_o}, {m_wel, m_rwel});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule